// File: doc/BRIEF.md
# UART Receive Buffer and Interrupt Identification

This block sits between the receive shifter of a 16550-style serial port and the processor's register interface. Each time the shifter completes a character, it presents the data byte and three error flags (parity, framing, break) for one cycle. The block stores the character together with its flags. In FIFO mode the store is a 16-entry queue. In non-FIFO mode it is a single holding register. The block tracks overrun and produces one registered interrupt request.

Software reaches the block through a two-bit register address with read and write strobes. The four registers are received data, interrupt enables, a shared location (identification on read, FIFO control on write) and line status. The identification register names the highest-priority source that is both active and enabled. Line status ranks above data available, which ranks above character timeout. Its pending bit is active-low.

Top module: `uart_rx_irq`

## Requirements
- R1: After a synchronous reset the block is in non-FIFO mode, both enables are 0, identification reads 0x01, the enable register reads 0x00, line status reads 0x00 and `irq_o` is 0.
- R2: Identification (read of address 2) holds these fields. Bit 0 is the pending bit: 0 when a source is pending, 1 when none is. Bits 3:1 give the source: 3 for line status, 2 for receive data available, 6 for character timeout, 0 for none. Bits 7:6 read 11 in FIFO mode and 00 in non-FIFO mode. The other bits read 0.
- R3: The enable register (address 1) has two bits. Bit 0 admits receive-data and timeout sources. Bit 1 admits the line-status source. A source whose bit is 0 never pends. `irq_o` is 1 exactly when identification bit 0 is 0, one clock later.
- R4: A FIFO-control write (address 2) whose bit 0 is 0 selects non-FIFO mode and empties the receive store. In non-FIFO mode a single stored character makes receive data available.
- R5: A FIFO-control write with bit 0 set to 1 selects FIFO mode and loads the trigger code from bits 7:6. It empties the store if bit 1 is 1 or if the mode changes. Bit 1 is not retained, so a later write without it leaves the store intact.
- R6: Trigger codes 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 entries. In FIFO mode, receive data available is active while the occupancy is at or above the threshold, and it drops when reads take the occupancy below it.
- R7: Reading address 0 removes and returns the oldest stored character, in arrival order. Reading it when the store is empty returns 0x00. Every register read value appears on `reg_rdata` in the cycle after the read strobe.
- R8: In FIFO mode, a character that arrives while 16 entries are held is discarded and sets the overrun flag. The 16 held characters are not changed.
- R9: In non-FIFO mode, a character that arrives while the holding register is unread replaces it and sets the overrun flag.
- R10: Line status (address 3) has bit 0 for data ready and bit 1 for overrun. Bits 2, 3 and 4 give the parity, framing and break flags of the oldest stored character. Reading line status clears only the overrun flag.
- R11: The line-status source is active while overrun is set or the oldest stored character carries an error flag. It outranks receive data available, which outranks timeout.
- R12: A one-cycle `rx_timeout` pulse in FIFO mode with data stored raises the timeout source. A data read, an empty store or a store clear removes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a character is complete |
| rx_char | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error flag of the character |
| rx_frm_err | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| rx_timeout | input | 1 | One-cycle character-timeout indication |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 data, 1 enable, 2 identification/FIFO control, 3 line status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest state to reach from the ports is a FIFO-mode overrun. The queue must hold exactly sixteen entries with no read in between, and then a seventeenth character must arrive. The bench arms the line-status enable and a trigger of eight, then pushes seventeen consecutive characters. It then drains all sixteen and compares each one against the pushed sequence, which shows that the extra character never entered the queue. A second hard case is a parity error sitting behind clean characters. Its line-status source must stay hidden until the entries ahead of it have been read, and the table-driven part walks through exactly that order.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ID_NONE  = 3'd0,
    ID_RDA   = 3'd2,
    ID_LSTAT = 3'd3,
    ID_TMO   = 3'd6
  } irq_id_e;

  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             single,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    level,
  output logic             empty,
  output logic             overflow
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_addr;
  logic [CW-1:0]    cnt;
  logic             full, do_pop, accept, overwrite;

  always_comb begin
    full      = single ? (cnt != '0) : (cnt == CW'(DEPTH));
    do_pop    = pop && (cnt != '0);
    accept    = push && (!full || do_pop);
    overwrite = push && single && full && !do_pop;
    overflow  = push && full && !do_pop;
    wr_addr   = overwrite ? rd_ptr : wr_ptr;
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if ((accept || overwrite) && !clr)
      mem[wr_addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop) rd_ptr <= rd_ptr + AW'(1);
      cnt <= cnt + CW'(accept) - CW'(do_pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign level = cnt;
  assign empty = (cnt == '0);

  p_level_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (push && !single && (cnt == CW'(DEPTH)) && !pop && !clr) |=> (cnt == $past(cnt)));

  p_single_depth_r9: assert property (@(posedge clk) disable iff (rst)
    single |-> (cnt <= CW'(1)));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

endmodule

// File: rtl/rx_irq_ident.sv
module rx_irq_ident
  import uart_rx_pkg::*;
(
  input  logic       fifo_mode,
  input  logic       en_rx,
  input  logic       en_ls,
  input  logic       ls_act,
  input  logic       rda_act,
  input  logic       tmo_act,
  output logic [7:0] ident
);

  irq_id_e id;

  always_comb begin
    if (en_ls && ls_act)       id = ID_LSTAT;
    else if (en_rx && rda_act) id = ID_RDA;
    else if (en_rx && tmo_act) id = ID_TMO;
    else                       id = ID_NONE;
    ident = {fifo_mode, fifo_mode, 2'b00, id, (id == ID_NONE)};
  end

endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_char,
  input  logic       rx_par_err,
  input  logic       rx_frm_err,
  input  logic       rx_brk,
  input  logic       rx_timeout,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_o
);

  logic               fifo_en, oe, tmo_flag;
  logic [1:0]         trig, ier;
  logic [ENTRY_W-1:0] wentry, head_bits;
  rx_entry_t          head;
  logic [CW-1:0]      level, thresh;
  logic               empty, overflow;
  logic               wr_ier, wr_fcr, rd_data, rd_lsr, fifo_clr;
  logic               head_err, ls_act, rda_act;
  logic [7:0]         lsr, ident;
  logic               unused_wbits;

  assign unused_wbits = ^reg_wdata[5:2];

  always_comb begin
    wr_ier   = reg_wr && (reg_addr == 2'd1);
    wr_fcr   = reg_wr && (reg_addr == 2'd2);
    rd_data  = reg_rd && (reg_addr == 2'd0);
    rd_lsr   = reg_rd && (reg_addr == 2'd3);
    fifo_clr = wr_fcr && (!reg_wdata[0] || reg_wdata[1] || !fifo_en);
    wentry   = {rx_brk, rx_frm_err, rx_par_err, rx_char};
    head     = rx_entry_t'(head_bits);
    thresh   = fifo_en ? CW'(trig_level(trig)) : CW'(1);
    rda_act  = (level >= thresh);
    head_err = !empty && (head.par || head.frm || head.brk);
    ls_act   = oe || head_err;
    lsr      = {3'b000, !empty && head.brk, !empty && head.frm,
                !empty && head.par, oe, !empty};
  end

  rx_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) i_fifo (
    .clk      (clk),
    .rst      (rst),
    .clr      (fifo_clr),
    .single   (!fifo_en),
    .push     (rx_valid),
    .wdata    (wentry),
    .pop      (rd_data),
    .head     (head_bits),
    .level    (level),
    .empty    (empty),
    .overflow (overflow)
  );

  rx_irq_ident i_ident (
    .fifo_mode (fifo_en),
    .en_rx     (ier[0]),
    .en_ls     (ier[1]),
    .ls_act    (ls_act),
    .rda_act   (rda_act),
    .tmo_act   (tmo_flag),
    .ident     (ident)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en   <= 1'b0;
      trig      <= 2'd0;
      ier       <= 2'd0;
      oe        <= 1'b0;
      tmo_flag  <= 1'b0;
      irq_o     <= 1'b0;
      reg_rdata <= 8'h00;
    end else begin
      if (wr_fcr) begin
        fifo_en <= reg_wdata[0];
        if (reg_wdata[0]) trig <= reg_wdata[7:6];
      end
      if (wr_ier) ier <= reg_wdata[1:0];

      if (overflow) oe <= 1'b1;
      else if (rd_lsr) oe <= 1'b0;

      if (fifo_clr || rd_data || empty) tmo_flag <= 1'b0;
      else if (rx_timeout && fifo_en) tmo_flag <= 1'b1;

      irq_o <= !ident[0];

      if (reg_rd) begin
        case (reg_addr)
          2'd0:    reg_rdata <= empty ? 8'h00 : head.data;
          2'd1:    reg_rdata <= {6'b0, ier};
          2'd2:    reg_rdata <= ident;
          default: reg_rdata <= lsr;
        endcase
      end
    end
  end

  p_oe_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_lsr && !overflow) |=> !oe);

  p_tmo_has_data_r12: assert property (@(posedge clk) disable iff (rst)
    tmo_flag |-> !empty);

  p_ls_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (ier[1] && oe) |-> (ident[3:1] == 3'd3));

endmodule

// File: tb/test_uart_rx_irq.sv
module test_uart_rx_irq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
  logic       rx_timeout = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] rx_char = 8'h00, reg_wdata = 8'h00;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_rdata;
  logic       irq_o;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  uart_rx_irq i_uart_rx_irq (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
    .rx_timeout(rx_timeout), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  // op: 0 write, 1 read-check, 2 push {brk,frm,par,data}, 3 timeout pulse, 4 irq check
  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  addr;
    logic [10:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd1, 11'h003, 4'd3},  '{3'd2, 2'd0, 11'h041, 4'd9},
    '{3'd4, 2'd0, 11'h001, 4'd3},  '{3'd1, 2'd2, 11'h004, 4'd2},
    '{3'd2, 2'd0, 11'h042, 4'd9},  '{3'd1, 2'd2, 11'h006, 4'd11},
    '{3'd1, 2'd3, 11'h003, 4'd10}, '{3'd1, 2'd3, 11'h001, 4'd10},
    '{3'd1, 2'd0, 11'h042, 4'd9},  '{3'd1, 2'd3, 11'h000, 4'd7},
    '{3'd4, 2'd0, 11'h000, 4'd3},  '{3'd0, 2'd2, 11'h041, 4'd5},
    '{3'd1, 2'd2, 11'h0C1, 4'd2},  '{3'd2, 2'd0, 11'h010, 4'd7},
    '{3'd2, 2'd0, 11'h011, 4'd7},  '{3'd2, 2'd0, 11'h012, 4'd7},
    '{3'd1, 2'd2, 11'h0C1, 4'd6},  '{3'd2, 2'd0, 11'h013, 4'd7},
    '{3'd1, 2'd2, 11'h0C4, 4'd6},  '{3'd1, 2'd0, 11'h010, 4'd7},
    '{3'd1, 2'd2, 11'h0C1, 4'd6},  '{3'd3, 2'd0, 11'h000, 4'd12},
    '{3'd1, 2'd2, 11'h0CC, 4'd12}, '{3'd1, 2'd0, 11'h011, 4'd12},
    '{3'd1, 2'd2, 11'h0C1, 4'd12}, '{3'd2, 2'd0, 11'h155, 4'd10},
    '{3'd1, 2'd3, 11'h001, 4'd10}, '{3'd1, 2'd0, 11'h012, 4'd7},
    '{3'd1, 2'd0, 11'h013, 4'd7},  '{3'd1, 2'd3, 11'h005, 4'd10},
    '{3'd1, 2'd2, 11'h0C6, 4'd11}, '{3'd0, 2'd1, 11'h001, 4'd3},
    '{3'd1, 2'd2, 11'h0C1, 4'd3},  '{3'd4, 2'd0, 11'h000, 4'd3},
    '{3'd0, 2'd2, 11'h0C3, 4'd5},  '{3'd1, 2'd3, 11'h000, 4'd5},
    '{3'd2, 2'd0, 11'h020, 4'd5},  '{3'd0, 2'd2, 11'h0C1, 4'd5},
    '{3'd1, 2'd3, 11'h001, 4'd5},  '{3'd0, 2'd2, 11'h000, 4'd4},
    '{3'd1, 2'd2, 11'h001, 4'd4},  '{3'd1, 2'd3, 11'h000, 4'd4},
    '{3'd2, 2'd0, 11'h033, 4'd4},  '{3'd1, 2'd2, 11'h004, 4'd4}
  };

  function automatic string rtag(input logic [3:0] n);
    case (n)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    check(reg_rdata, exp, tag);
  endtask

  task automatic push(input logic [10:0] v);
    rx_valid = 1'b1; {rx_brk, rx_frm_err, rx_par_err, rx_char} = v;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0; {rx_brk, rx_frm_err, rx_par_err} = 3'b000;
  endtask

  task automatic tmo_pulse();
    rx_timeout = 1'b1;
    @(posedge clk); @(negedge clk);
    rx_timeout = 1'b0;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(posedge clk); @(negedge clk);
    check({7'b0, irq_o}, {7'b0, exp}, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd2, 8'h01, "R1");
    rd(2'd1, 8'h00, "R1");
    rd(2'd3, 8'h00, "R1");
    check({7'b0, irq_o}, 8'h00, "R1");

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        3'd0: wr(VEC[i].addr, VEC[i].val[7:0]);
        3'd1: rd(VEC[i].addr, VEC[i].val[7:0], rtag(VEC[i].req));
        3'd2: push(VEC[i].val);
        3'd3: tmo_pulse();
        default: irq_chk(VEC[i].val[0], rtag(VEC[i].req));
      endcase
    end

    // R8: FIFO-mode overrun with trigger of 8 (R6)
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h81);
    for (int i = 0; i < 7; i++) push({3'b000, 8'(8'h80 + i)});
    rd(2'd2, 8'hC1, "R6");
    push(11'h087);
    rd(2'd2, 8'hC4, "R6");
    for (int i = 8; i < 16; i++) push({3'b000, 8'(8'h80 + i)});
    rd(2'd3, 8'h01, "R8");
    push(11'h0EE);
    rd(2'd2, 8'hC6, "R8");
    rd(2'd3, 8'h03, "R8");
    for (int i = 0; i < 16; i++) rd(2'd0, 8'(8'h80 + i), "R8");
    rd(2'd3, 8'h00, "R8");
    rd(2'd0, 8'h00, "R7");

    // R6: trigger code 3 = 14 entries, then code 0 = 1 entry
    wr(2'd2, 8'hC3);
    for (int i = 0; i < 13; i++) push({3'b000, 8'(8'h40 + i)});
    rd(2'd2, 8'hC1, "R6");
    push(11'h04D);
    rd(2'd2, 8'hC4, "R6");
    wr(2'd2, 8'h03);
    rd(2'd2, 8'hC1, "R6");
    push(11'h099);
    rd(2'd2, 8'hC4, "R6");
    irq_chk(1'b1, "R3");

    finish_run();
  end

endmodule